// File: doc/BRIEF.md
# CAN Controller Mode Control Unit

This unit holds the mode configuration register of a CAN controller and sequences its low-power stop, debug (freeze) and soft-reset states. A host reaches the register through a single-register bus carrying a privilege flag; supervisor-only protection can reject user-mode accesses. The unit drives the enables for the module clocks, the bit-time prescaler and the message-buffer transfer logic. It also drives a soft-reset strobe for the internal state and a wake interrupt request.

Debug mode is requested by an external freeze line or by the register's halt bit. Both requests only take effect while freeze enable is set. The host polls the freeze acknowledge bit to learn that the prescaler has stopped. Stop mode gates the module clocks. A bus wake event can release stop mode by itself when self-wake is enabled. A soft reset returns the register to its reset values, runs for a fixed number of cycles and clears itself.

Top module: `canmode_ctrl`

## Requirements
- R1: The register is 16 bits wide and uses MSB-first numbering, so field k sits at data bit 15-k. The fields are: 0 stop, 1 freeze enable, 3 halt, 4 not-ready, 5 wake mask, 6 soft reset, 7 freeze acknowledge, 8 supervisor-only. Field 2 and fields 9..15 read 0. After reset, freeze enable, halt and supervisor-only are 1 and all other fields are 0.
- R2: Only an accepted host write sets the stop bit. An accepted host write of 0 clears it. `clk_en` is the inverse of stop.
- R3: When stop is 1 and `self_wake_en` is 1, a `wake_evt` clears stop at that edge. With `self_wake_en` at 0, `wake_evt` leaves stop unchanged.
- R4: The debug state follows, one edge later, freeze enable AND (`freeze_in` OR halt). With freeze enable at 0, both requests are ignored, and clearing freeze enable forces an exit.
- R5: `presc_en` falls one edge after debug is entered and rises one edge after debug is left. Freeze acknowledge sets one edge after entry. It clears only at the edge after `presc_en` has risen.
- R6: Not-ready reads 1 one edge after the unit is in stop or debug, and reads 0 one edge after it has left both.
- R7: `xfer_en` is 1 only when halt is 0 and the unit is not in debug, not in stop and not in a soft reset.
- R8: The supervisor-only bit changes on a write only while halt is 1. Otherwise the write leaves it unchanged.
- R9: While supervisor-only is 1, a user access (`req_super`=0) gives `resp_err`=1 and `rd_data`=0, and changes no register state. Supervisor accesses are always accepted. User accesses are accepted while supervisor-only is 0.
- R10: An accepted write with the soft-reset field at 1 holds `srst_pulse` high for exactly SRST_CYCLES cycles. The soft-reset field reads 1 during that time. The register returns to its reset values, with stop cleared.
- R11: Host writes that arrive while a soft reset is running are ignored.
- R12: `wake_irq` is a one-cycle pulse, one edge after a `wake_evt` that arrives while stop is 1. It appears only when the wake mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access to the register in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_super | input | 1 | 1 when the access has supervisor privilege |
| req_wdata | input | 16 | Write data, MSB-first field layout |
| rd_data | output | 16 | Read data (0 when idle or rejected) |
| resp_err | output | 1 | Access rejected for lack of privilege |
| freeze_in | input | 1 | External debug freeze request |
| wake_evt | input | 1 | Bus synchronization / wake event |
| self_wake_en | input | 1 | Lets a wake event clear stop |
| clk_en | output | 1 | Module clock enable |
| presc_en | output | 1 | Bit-time prescaler enable |
| xfer_en | output | 1 | Message-buffer receive/transmit enable |
| srst_pulse | output | 1 | Soft reset strobe for internal state |
| wake_irq | output | 1 | Wake interrupt request |

## Verification
The bench builds the unit with SRST_CYCLES at its default of 4. This keeps the whole soft-reset window short enough to be counted cycle by cycle, and to place a host write inside it before it closes. The register stays at 16 bits, so every MSB-first field position can be written and read back as a literal word. The bench samples between edges at each step of the debug entry and exit. This exposes the one-edge lags between the debug state, the prescaler enable and the acknowledge.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

  localparam int REG_W = 16;
  localparam int IW    = $clog2(REG_W);

  typedef logic [IW-1:0] idx_t;

  // Field numbers, MSB-first (field k sits at data bit REG_W-1-k)
  localparam int F_STOP = 0;
  localparam int F_FRZE = 1;
  localparam int F_HALT = 3;
  localparam int F_NRDY = 4;
  localparam int F_WMSK = 5;
  localparam int F_SRST = 6;
  localparam int F_FACK = 7;
  localparam int F_SUPV = 8;

  typedef struct packed {
    logic stop;
    logic frz_en;
    logic halt;
    logic wake_msk;
    logic sup_only;
  } ctl_t;

  localparam ctl_t CTL_RST = '{stop: 1'b0, frz_en: 1'b1, halt: 1'b1,
                               wake_msk: 1'b0, sup_only: 1'b1};

  function automatic idx_t pos(input int f);
    return idx_t'(REG_W - 1 - f);
  endfunction

  function automatic logic field(input logic [REG_W-1:0] w, input int f);
    return w[pos(f)];
  endfunction

  function automatic logic dbg_wanted(input logic frz_en, input logic frz_line,
                                      input logic halt);
    return frz_en & (frz_line | halt);
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input ctl_t c, input logic nrdy,
                                                 input logic srst, input logic fack);
    logic [REG_W-1:0] w;
    w = '0;
    w[pos(F_STOP)] = c.stop;
    w[pos(F_FRZE)] = c.frz_en;
    w[pos(F_HALT)] = c.halt;
    w[pos(F_NRDY)] = nrdy;
    w[pos(F_WMSK)] = c.wake_msk;
    w[pos(F_SRST)] = srst;
    w[pos(F_FACK)] = fack;
    w[pos(F_SUPV)] = c.sup_only;
    return w;
  endfunction

endpackage

// File: rtl/canmode_srst.sv
module canmode_srst #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start && cnt == '0)
      cnt <= CW'(CYCLES);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/canmode_dbg.sv
module canmode_dbg
  import canmode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic frz_en,
  input  logic halt,
  input  logic frz_line,
  input  logic stop,
  output logic in_dbg,
  output logic presc_en,
  output logic frz_ack,
  output logic not_rdy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_dbg   <= 1'b0;
      presc_en <= 1'b1;
      frz_ack  <= 1'b0;
      not_rdy  <= 1'b0;
    end else begin
      in_dbg   <= !hold && dbg_wanted(frz_en, frz_line, halt);
      presc_en <= !in_dbg;
      if (in_dbg)
        frz_ack <= 1'b1;
      else if (presc_en)
        frz_ack <= 1'b0;
      not_rdy  <= in_dbg | stop;
    end
  end
endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl
  import canmode_pkg::*;
#(
  parameter int SRST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_super,
  input  logic [REG_W-1:0] req_wdata,
  output logic [REG_W-1:0] rd_data,
  output logic             resp_err,
  input  logic             freeze_in,
  input  logic             wake_evt,
  input  logic             self_wake_en,
  output logic             clk_en,
  output logic             presc_en,
  output logic             xfer_en,
  output logic             srst_pulse,
  output logic             wake_irq
);
  ctl_t ctl_q, ctl_d;
  logic priv_block, wr_ok, srst_start, srst_busy, wake_self;
  logic in_dbg, frz_ack, not_rdy;

  // named events for the checker
  assign priv_block = req_valid & ~req_super & ctl_q.sup_only;
  assign wr_ok      = req_valid & req_write & ~priv_block & ~srst_busy;
  assign srst_start = wr_ok & field(req_wdata, F_SRST);
  assign wake_self  = wake_evt & self_wake_en & ctl_q.stop;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ok) begin
      ctl_d.stop     = field(req_wdata, F_STOP);
      ctl_d.frz_en   = field(req_wdata, F_FRZE);
      ctl_d.halt     = field(req_wdata, F_HALT);
      ctl_d.wake_msk = field(req_wdata, F_WMSK);
      if (ctl_q.halt)
        ctl_d.sup_only = field(req_wdata, F_SUPV);
    end
    if (wake_self)
      ctl_d.stop = 1'b0;
    if (srst_start)
      ctl_d = CTL_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= CTL_RST;
      wake_irq <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      wake_irq <= wake_evt & ctl_q.stop & ctl_q.wake_msk;
    end
  end

  canmode_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy)
  );

  canmode_dbg u_dbg (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (srst_busy),
    .frz_en   (ctl_q.frz_en),
    .halt     (ctl_q.halt),
    .frz_line (freeze_in),
    .stop     (ctl_q.stop),
    .in_dbg   (in_dbg),
    .presc_en (presc_en),
    .frz_ack  (frz_ack),
    .not_rdy  (not_rdy)
  );

  assign rd_data    = (req_valid && !priv_block) ?
                      pack_word(ctl_q, not_rdy, srst_busy, frz_ack) : '0;
  assign resp_err   = priv_block;
  assign clk_en     = ~ctl_q.stop;
  assign xfer_en    = ~ctl_q.halt & ~in_dbg & ~ctl_q.stop & ~srst_busy;
  assign srst_pulse = srst_busy;
endmodule

// File: rtl/canmode_chk.sv
module canmode_chk #(
  parameter int SRST_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ok,
  input logic       stop_q,
  input logic       wake_msk_q,
  input logic [3:0] ctl_keep,
  input logic       frz_ack,
  input logic       presc_en,
  input logic       srst_pulse,
  input logic       wake_irq,
  input logic       resp_err
);
  localparam int RW = $clog2(SRST_CYCLES + 2);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= '0;
    else if (srst_pulse) run <= run + RW'(1);
    else                 run <= '0;
  end

  // R2: stop only rises after an accepted host write
  a_r2_stop_set_by_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(wr_ok));

  // R5: acknowledge drops only once the prescaler is running again
  a_r5_ack_after_presc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frz_ack) |-> $past(presc_en));

  // R9: a rejected access leaves the register unchanged
  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |=> $stable(ctl_keep));

  // R10: the soft reset strobe lasts exactly SRST_CYCLES cycles
  a_r10_srst_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_pulse) |-> (run == RW'(SRST_CYCLES)));

  // R12: no wake request while the mask is clear
  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(wake_msk_q));
endmodule

bind canmode_ctrl canmode_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ok      (wr_ok),
  .stop_q     (ctl_q.stop),
  .wake_msk_q (ctl_q.wake_msk),
  .ctl_keep   ({ctl_q.frz_en, ctl_q.halt, ctl_q.wake_msk, ctl_q.sup_only}),
  .frz_ack    (frz_ack),
  .presc_en   (presc_en),
  .srst_pulse (srst_pulse),
  .wake_irq   (wake_irq),
  .resp_err   (resp_err)
);

// File: tb/canmode_ctrl_bench.sv
`timescale 1ns/100ps
module canmode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rd_data;
  logic        resp_err;
  logic        freeze_in = 1'b0, wake_evt = 1'b0, self_wake_en = 1'b0;
  logic        clk_en, presc_en, xfer_en, srst_pulse, wake_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  canmode_ctrl #(.SRST_CYCLES(4)) u_canmode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_super(req_super), .req_wdata(req_wdata), .rd_data(rd_data),
    .resp_err(resp_err), .freeze_in(freeze_in), .wake_evt(wake_evt),
    .self_wake_en(self_wake_en), .clk_en(clk_en), .presc_en(presc_en),
    .xfer_en(xfer_en), .srst_pulse(srst_pulse), .wake_irq(wake_irq)
  );

  // word builder: field k at bit 15-k
  function automatic logic [15:0] mk(input bit stop, input bit frz, input bit halt,
                                     input bit nrdy, input bit wmsk, input bit srst,
                                     input bit fack, input bit supv);
    logic [15:0] w = '0;
    w[15] = stop; w[14] = frz; w[12] = halt; w[11] = nrdy;
    w[10] = wmsk; w[9] = srst; w[8] = fack; w[7] = supv;
    return w;
  endfunction

  typedef struct {
    bit          is_read;
    logic [15:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input bit sup, input logic [15:0] wd,
                     input logic [15:0] exp_rd, input logic exp_err, input string tag);
    exp_t e;
    e.is_read = !wr; e.data = exp_rd; e.err = exp_err; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_super = sup; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic rd(input bit sup, input logic [15:0] exp_rd, input logic exp_err,
                    input string tag);
    bus(1'b0, sup, '0, exp_rd, exp_err, tag);
  endtask

  task automatic wr(input bit sup, input logic [15:0] wd, input logic exp_err,
                    input string tag);
    bus(1'b1, sup, wd, '0, exp_err, tag);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every bus cycle
  always @(negedge clk) begin
    #1;
    if (req_valid) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard-empty actual=%h expected=none", rd_data);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " err"}, {15'd0, resp_err}, {15'd0, e.err});
        if (e.is_read) check({e.tag, " data"}, rd_data, e.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    #1;
    // reset state
    check("R5 presc off in reset debug", {15'd0, presc_en}, 16'd0);
    check("R2 clk_en after reset", {15'd0, clk_en}, 16'd1);
    check("R7 xfer off while halted", {15'd0, xfer_en}, 16'd0);
    check("R10 no strobe after reset", {15'd0, srst_pulse}, 16'd0);
    rd(1, mk(0,1,1,1,0,0,1,1), 0, "R1 reset word");
    rd(0, 16'h0000, 1, "R9 user read blocked");
    wr(0, mk(0,1,0,0,0,0,0,1), 1, "R9 user write blocked");
    rd(1, mk(0,1,1,1,0,0,1,1), 0, "R9 state unchanged");

    // leave debug by clearing halt, watch the ordering
    wr(1, mk(0,1,0,0,0,0,0,1), 0, "R4 clear halt");
    idle(1);
    rd(1, mk(0,1,0,0,0,0,1,1), 0, "R5 ack held until presc up");
    check("R5 presc up after exit", {15'd0, presc_en}, 16'd1);
    rd(1, mk(0,1,0,0,0,0,0,1), 0, "R5 ack released");
    #1;
    check("R7 xfer on when running", {15'd0, xfer_en}, 16'd1);

    // freeze line entry and exit
    freeze_in = 1'b1;
    step();
    check("R5 presc still on one edge after request", {15'd0, presc_en}, 16'd1);
    check("R7 xfer off in debug", {15'd0, xfer_en}, 16'd0);
    step();
    check("R5 presc off one edge after entry", {15'd0, presc_en}, 16'd0);
    rd(1, mk(0,1,0,1,0,0,1,1), 0, "R4 R6 debug via freeze line");
    #1;
    freeze_in = 1'b0;
    step();
    rd(1, mk(0,1,0,0,0,0,1,1), 0, "R6 nrdy cleared R5 ack held");
    check("R5 presc back", {15'd0, presc_en}, 16'd1);
    rd(1, mk(0,1,0,0,0,0,0,1), 0, "R5 ack cleared after presc");

    // freeze enable gating
    wr(1, mk(0,0,0,0,0,0,0,1), 0, "R4 freeze disable");
    freeze_in = 1'b1;
    idle(3); #1;
    check("R4 freeze ignored when disabled", {15'd0, presc_en}, 16'd1);
    rd(1, mk(0,0,0,0,0,0,0,1), 0, "R4 no debug when disabled");
    wr(1, mk(0,1,0,0,0,0,0,1), 0, "R4 freeze enable");
    idle(3); #1;
    check("R4 debug with freeze enabled", {15'd0, presc_en}, 16'd0);
    rd(1, mk(0,1,0,1,0,0,1,1), 0, "R4 debug word");
    wr(1, mk(0,0,0,0,0,0,0,1), 0, "R4 forced exit");
    idle(4); #1;
    check("R4 forced exit presc", {15'd0, presc_en}, 16'd1);
    rd(1, mk(0,0,0,0,0,0,0,1), 0, "R4 forced exit word");
    freeze_in = 1'b0;

    // supervisor-only lock
    wr(1, mk(0,0,0,0,0,0,0,0), 0, "R8 sup write when not halted");
    rd(1, mk(0,0,0,0,0,0,0,1), 0, "R8 sup kept");
    wr(1, mk(0,0,1,0,0,0,0,1), 0, "R8 set halt");
    wr(1, mk(0,0,1,0,0,0,0,0), 0, "R8 sup write while halted");
    rd(0, mk(0,0,1,0,0,0,0,0), 0, "R8 R9 user read allowed");
    #1;
    check("R7 xfer off with halt", {15'd0, xfer_en}, 16'd0);
    wr(0, mk(0,0,0,0,0,0,0,0), 0, "R9 user write allowed");
    #1;
    check("R7 xfer on", {15'd0, xfer_en}, 16'd1);

    // stop and wake
    wr(0, mk(1,0,0,0,0,0,0,0), 0, "R2 set stop");
    #1;
    check("R2 clk gated", {15'd0, clk_en}, 16'd0);
    check("R7 xfer off in stop", {15'd0, xfer_en}, 16'd0);
    idle(2);
    rd(0, mk(1,0,0,1,0,0,0,0), 0, "R6 nrdy in stop");
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    check("R12 masked wake", {15'd0, wake_irq}, 16'd0);
    check("R3 no self wake", {15'd0, clk_en}, 16'd0);
    wr(0, mk(1,0,0,0,1,0,0,0), 0, "R12 unmask");
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    check("R12 wake irq", {15'd0, wake_irq}, 16'd1);
    check("R3 stop kept without self wake", {15'd0, clk_en}, 16'd0);
    step();
    check("R12 one cycle pulse", {15'd0, wake_irq}, 16'd0);
    self_wake_en = 1'b1;
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    check("R3 self wake clears stop", {15'd0, clk_en}, 16'd1);
    self_wake_en = 1'b0;
    idle(2);
    rd(0, mk(0,0,0,0,1,0,0,0), 0, "R3 R6 after wake");
    #1;
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    check("R12 no irq when running", {15'd0, wake_irq}, 16'd0);
    wr(0, mk(1,0,0,0,1,0,0,0), 0, "R2 stop again");
    wr(0, mk(0,0,0,0,1,0,0,0), 0, "R2 host clears stop");
    #1;
    check("R2 clk restored", {15'd0, clk_en}, 16'd1);

    // soft reset
    wr(0, mk(1,0,0,0,1,0,0,0), 0, "R10 prep");
    wr(0, mk(1,0,0,0,1,1,0,0), 0, "R10 start");
    begin
      int n = 0;
      #1;
      check("R10 stop cleared", {15'd0, clk_en}, 16'd1);
      while (srst_pulse && n < 50) begin
        n++;
        @(negedge clk); #1;
      end
      check("R10 strobe length", 16'(n), 16'd4);
    end
    idle(4);
    rd(1, mk(0,1,1,1,0,0,1,1), 0, "R10 defaults back");
    wr(1, mk(0,1,1,0,0,1,0,1), 0, "R10 second start");
    rd(1, mk(0,1,1,1,0,1,1,1), 0, "R10 srst bit reads 1");
    wr(1, mk(0,1,0,0,1,0,0,1), 0, "R11 write during reset");
    idle(6);
    rd(1, mk(0,1,1,1,0,0,1,1), 0, "R11 write ignored");

    idle(2);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard-leftover actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule